// File: doc/BRIEF.md
# DRAM Refresh and Wake-up Scheduler

This block sits on the controller side of an asynchronous DRAM with 512 rows. It keeps the rows refreshed and brings the device up after power-on. A free-running interval counter raises refresh demands. Demands that cannot be served at once are held in a small saturating pending counter. Each demand is served by arbitrating with the access engine through a request/grant pair. For each refresh the block drives the row strobe, the two column strobes and the row address bus from registers. Two kinds of refresh cycle are available. In the CAS-before-RAS kind the device supplies the row. In the RAS-only kind the block presents a row from its own counter.

After reset the block stays quiet for a power-up pause. It then runs a burst of wake-up refreshes. Only after the last one does it declare the memory ready. If the backlog of demands overflows, the retention window has been missed. The block then withdraws the ready indication, throws away the backlog and runs the whole wake-up burst again.

All timing values are parameters counted in clock cycles. Their defaults are derived from a clock-frequency parameter: a 200 µs pause, a 15.6 µs refresh interval, 60 ns minimum strobe-low time and 40 ns minimum precharge.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held and on the first cycle after it, ras_n, casl_n and cash_n are 1, row_addr is 0, and ref_req, ref_done, mem_ready and overdue are 0.
- R2: For the first INIT_CYC clock edges after reset is released, ref_req stays 0 and ras_n stays 1.
- R3: After the pause, exactly WAKE_CNT refresh cycles complete before mem_ready becomes 1. mem_ready rises in the same cycle as the last of those ref_done pulses.
- R4: While mem_ready is 1, one refresh demand is added every REFI_CYC cycles. ref_req is 1 while the sequencer is idle and a demand or a wake-up cycle is outstanding.
- R5: A refresh starts only on a clock edge where ref_req and ref_gnt are both 1. ref_done is a one-cycle pulse, given when T_RP precharge cycles have followed the strobe-low phase.
- R6: With rasonly_sel=0 sampled at grant (CBR), casl_n and cash_n go to 0 together T_CSR cycles before ras_n falls. They stay 0 while ras_n is low for T_RAS cycles and return to 1 together with ras_n.
- R7: With rasonly_sel=1 sampled at grant, both CAS lines stay 1 and row_addr carries the internal row count while ras_n is low. The count advances by one after each such refresh and wraps from 2^ROW_BITS-1 to 0.
- R8: rasonly_sel is sampled only on the granting edge. Changes to it while a refresh is in progress do not alter that refresh's strobes.
- R9: The pending count saturates at PEND_MAX. overdue is 1 exactly while the count equals PEND_MAX.
- R10: If a demand arrives while the count is at PEND_MAX and no refresh completes on that edge, mem_ready falls, the backlog is cleared, and WAKE_CNT refresh cycles run again before mem_ready returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rasonly_sel | input | 1 | 1 selects a RAS-only refresh, 0 a CAS-before-RAS refresh; sampled at grant |
| ref_gnt | input | 1 | Grant from the access engine, given only between accesses |
| ref_req | output | 1 | Refresh request to the access engine |
| ref_done | output | 1 | One-cycle pulse at the end of a refresh's precharge |
| mem_ready | output | 1 | Memory initialised and usable for accesses |
| overdue | output | 1 | Pending refresh count is saturated |
| ras_n | output | 1 | Row strobe, active low |
| casl_n | output | 1 | Lower-byte column strobe, active low |
| cash_n | output | 1 | Upper-byte column strobe, active low |
| row_addr | output | ROW_BITS | Row address presented during RAS-only refresh |

## Verification
The properties assume that ref_gnt is only meaningful while ref_req is high. They also assume that rasonly_sel may change on any cycle, and that no timing parameter is zero. The bench drives both inputs only on the falling clock edge. It covers grants that are held high, grants that are withheld for long stretches and grants that come in sparse pulses. It also toggles rasonly_sel on every cycle in one phase, so that the sampling rule is stressed while staying within those assumptions. The grant gap that is long enough to force a missed retention window is chosen from the bench's own interval and saturation parameters.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_CSR,
    ST_RAS,
    ST_PRE
  } drs_state_e;
endpackage

// File: rtl/drs_tick_gen.sv
module drs_tick_gen #(
  parameter int PERIOD = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/drs_pending.sv
module drs_pending #(
  parameter int PEND_MAX = 8,
  localparam int PW = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [PW-1:0] cnt,
  output logic          full,
  output logic          miss
);
  localparam logic [PW-1:0] CAP = PW'(PEND_MAX);

  assign full = (cnt == CAP);
  assign miss = inc && full && !dec;

  always_ff @(posedge clk) begin
    if (rst || miss)
      cnt <= '0;
    else if (inc && !dec && !full)
      cnt <= cnt + 1'b1;
    else if (dec && !inc && cnt != '0)
      cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/drs_sequencer.sv
module drs_sequencer
  import drs_pkg::*;
#(
  parameter int INIT_CYC = 20000,
  parameter int T_RAS    = 6,
  parameter int T_RP     = 4,
  parameter int T_CSR    = 1,
  parameter int WAKE_CNT = 8,
  parameter int ROW_BITS = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rasonly_sel,
  input  logic                ref_gnt,
  input  logic                pend_nz,
  input  logic                miss,
  output logic                ref_req,
  output logic                ref_done,
  output logic                mem_ready,
  output logic                dec_pend,
  output logic                ras_n,
  output logic                casl_n,
  output logic                cash_n,
  output logic [ROW_BITS-1:0] row_addr
);
  localparam int M1   = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int M2   = (M1 > T_CSR) ? M1 : T_CSR;
  localparam int MAXC = (INIT_CYC > M2) ? INIT_CYC : M2;
  localparam int TW   = $clog2(MAXC + 1);
  localparam int WW   = $clog2(WAKE_CNT + 1);

  drs_state_e        state, nxt;
  logic [TW-1:0]     tmr;
  logic [WW-1:0]     wake_left;
  logic [ROW_BITS-1:0] row_q;
  logic              mode_q, mode_eff, start, fin;

  assign ref_req  = (state == ST_IDLE) && (wake_left != '0 || pend_nz);
  assign start    = ref_req && ref_gnt;
  assign fin      = (state == ST_PRE) && (tmr == TW'(T_RP - 1));
  assign dec_pend = fin && mem_ready;
  assign mode_eff = (state == ST_IDLE) ? rasonly_sel : mode_q;

  always_comb begin
    nxt = state;
    case (state)
      ST_PAUSE: if (tmr == TW'(INIT_CYC - 1)) nxt = ST_IDLE;
      ST_IDLE:  if (start) nxt = rasonly_sel ? ST_RAS : ST_CSR;
      ST_CSR:   if (tmr == TW'(T_CSR - 1)) nxt = ST_RAS;
      ST_RAS:   if (tmr == TW'(T_RAS - 1)) nxt = ST_PRE;
      ST_PRE:   if (fin) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_PAUSE;
      tmr       <= '0;
      mode_q    <= 1'b0;
      row_q     <= '0;
      row_addr  <= '0;
      ras_n     <= 1'b1;
      casl_n    <= 1'b1;
      cash_n    <= 1'b1;
      ref_done  <= 1'b0;
      wake_left <= WW'(WAKE_CNT);
      mem_ready <= 1'b0;
    end else begin
      state    <= nxt;
      tmr      <= (nxt != state) ? '0 : tmr + 1'b1;
      ref_done <= fin;
      ras_n    <= (nxt != ST_RAS);
      casl_n   <= !((nxt == ST_CSR) || (nxt == ST_RAS && !mode_eff));
      cash_n   <= !((nxt == ST_CSR) || (nxt == ST_RAS && !mode_eff));
      if (start) begin
        mode_q <= rasonly_sel;
        if (rasonly_sel) row_addr <= row_q;
      end
      if (fin && mode_q) row_q <= row_q + 1'b1;
      if (miss) begin
        wake_left <= WW'(WAKE_CNT);
        mem_ready <= 1'b0;
      end else if (fin && !mem_ready) begin
        wake_left <= wake_left - 1'b1;
        if (wake_left == WW'(1)) mem_ready <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int CLK_MHZ  = 100,
  parameter int INIT_CYC = 200 * CLK_MHZ,
  parameter int REFI_CYC = (15625 * CLK_MHZ) / 1000,
  parameter int T_RAS    = (60 * CLK_MHZ + 999) / 1000,
  parameter int T_RP     = (40 * CLK_MHZ + 999) / 1000,
  parameter int T_CSR    = (10 * CLK_MHZ + 999) / 1000,
  parameter int WAKE_CNT = 8,
  parameter int PEND_MAX = 8,
  parameter int ROW_BITS = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rasonly_sel,
  input  logic                ref_gnt,
  output logic                ref_req,
  output logic                ref_done,
  output logic                mem_ready,
  output logic                overdue,
  output logic                ras_n,
  output logic                casl_n,
  output logic                cash_n,
  output logic [ROW_BITS-1:0] row_addr
);
  localparam int PW = $clog2(PEND_MAX + 1);

  logic          tick, miss, dec_pend;
  logic [PW-1:0] pend_cnt;

  drs_tick_gen #(.PERIOD(REFI_CYC)) u_tick (
    .clk(clk), .rst(rst), .run(mem_ready), .tick(tick)
  );

  drs_pending #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk(clk), .rst(rst), .inc(tick), .dec(dec_pend),
    .cnt(pend_cnt), .full(overdue), .miss(miss)
  );

  drs_sequencer #(
    .INIT_CYC(INIT_CYC), .T_RAS(T_RAS), .T_RP(T_RP), .T_CSR(T_CSR),
    .WAKE_CNT(WAKE_CNT), .ROW_BITS(ROW_BITS)
  ) u_seq (
    .clk(clk), .rst(rst), .rasonly_sel(rasonly_sel), .ref_gnt(ref_gnt),
    .pend_nz(pend_cnt != '0), .miss(miss), .ref_req(ref_req),
    .ref_done(ref_done), .mem_ready(mem_ready), .dec_pend(dec_pend),
    .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n), .row_addr(row_addr)
  );
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
  parameter int T_RAS    = 6,
  parameter int T_RP     = 4,
  parameter int PEND_MAX = 8,
  localparam int PW = $clog2(PEND_MAX + 1),
  localparam int CW = $clog2(T_RAS + T_RP + 2) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          ras_n,
  input logic          casl_n,
  input logic          cash_n,
  input logic          ref_req,
  input logic          ref_gnt,
  input logic          ref_done,
  input logic [PW-1:0] pend_cnt
);
  localparam logic [CW-1:0] SAT = {CW{1'b1}};
  logic [CW-1:0] low_cnt, high_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= '0;
      high_cnt <= CW'(T_RP);
    end else if (!ras_n) begin
      low_cnt  <= (low_cnt == SAT) ? SAT : low_cnt + 1'b1;
      high_cnt <= '0;
    end else begin
      low_cnt  <= '0;
      high_cnt <= (high_cnt == SAT) ? SAT : high_cnt + 1'b1;
    end
  end

  assert_ras_low_min_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (low_cnt >= CW'(T_RAS)));

  assert_ras_high_min_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (high_cnt >= CW'(T_RP)));

  assert_cas_pair_R6: assert property (@(posedge clk) disable iff (rst)
    casl_n == cash_n);

  assert_cbr_cas_lead_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && !casl_n) |-> $past(!casl_n));

  assert_cbr_start_granted_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(casl_n) |-> $past(ref_req && ref_gnt));

  assert_rasonly_start_granted_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && casl_n) |-> $past(ref_req && ref_gnt));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    ref_done |=> !ref_done);

  assert_pend_cap_R9: assert property (@(posedge clk) disable iff (rst)
    pend_cnt <= PW'(PEND_MAX));
endmodule

bind dram_refresh_sched drs_checker #(
  .T_RAS(T_RAS), .T_RP(T_RP), .PEND_MAX(PEND_MAX)
) u_chk (
  .clk(clk), .rst(rst), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n),
  .ref_req(ref_req), .ref_gnt(ref_gnt), .ref_done(ref_done),
  .pend_cnt(pend_cnt)
);

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int INIT = 20;
  localparam int REFI = 30;
  localparam int TRAS = 3;
  localparam int TRP  = 2;
  localparam int TCSR = 1;
  localparam int WAKE = 8;
  localparam int PMAX = 4;
  localparam int RB   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode = 1'b0;
  logic gnt = 1'b0;
  logic req, done, ready, ovd, ras_n, casl_n, cash_n;
  logic [RB-1:0] addr;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  dram_refresh_sched #(
    .INIT_CYC(INIT), .REFI_CYC(REFI), .T_RAS(TRAS), .T_RP(TRP), .T_CSR(TCSR),
    .WAKE_CNT(WAKE), .PEND_MAX(PMAX), .ROW_BITS(RB)
  ) uut (
    .clk(clk), .rst(rst), .rasonly_sel(mode), .ref_gnt(gnt),
    .ref_req(req), .ref_done(done), .mem_ready(ready), .overdue(ovd),
    .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n), .row_addr(addr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Behavioural reference model: phases 0 pause, 1 idle, 2 cas lead, 3 strobe low, 4 precharge
  int m_phase, m_t, m_wake, m_pend, m_tick, m_row, m_addr;
  bit m_mode, m_ras, m_cas, m_done, m_ready;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_t = 0; m_wake = WAKE; m_pend = 0; m_tick = 0;
      m_row = 0; m_addr = 0; m_mode = 0; m_ras = 1; m_cas = 1;
      m_done = 0; m_ready = 0;
    end else begin
      bit tick, fin, dec, miss, rq, start;
      int nph;
      tick  = m_ready && (m_tick == REFI - 1);
      fin   = (m_phase == 4) && (m_t == TRP - 1);
      dec   = fin && m_ready;
      miss  = tick && (m_pend == PMAX) && !dec;
      rq    = (m_phase == 1) && (m_wake > 0 || m_pend > 0);
      start = rq && gnt;
      m_tick = m_ready ? (tick ? 0 : m_tick + 1) : 0;
      nph = m_phase;
      case (m_phase)
        0: if (m_t == INIT - 1) nph = 1;
        1: if (start) nph = mode ? 3 : 2;
        2: if (m_t == TCSR - 1) nph = 3;
        3: if (m_t == TRAS - 1) nph = 4;
        4: if (fin) nph = 1;
        default: nph = 1;
      endcase
      if (fin && m_mode) m_row = (m_row + 1) % (1 << RB);
      if (start) begin
        m_mode = mode;
        if (mode) m_addr = m_row;
      end
      m_ras = !(nph == 3);
      m_cas = !(nph == 2 || (nph == 3 && !m_mode));
      m_t = (nph != m_phase) ? 0 : m_t + 1;
      m_phase = nph;
      m_done = fin;
      if (miss) begin
        m_pend = 0; m_wake = WAKE; m_ready = 0;
      end else begin
        if (tick && !dec && m_pend < PMAX) m_pend++;
        else if (dec && !tick && m_pend > 0) m_pend--;
        if (fin && !m_ready) begin
          m_wake--;
          if (m_wake == 0) m_ready = 1;
        end
      end
    end
  end

  // Monitor: per-cycle comparison plus scenario statistics
  int edges_since = 0;
  int quiet_bad = 0;
  int wake_dones = 0;
  int wake_runs[$];
  int cbr_viol = 0;
  bit in_mode_phase = 0;
  bit prev_ras = 1, prev_ready = 0, cas_at_fall = 1;
  bit wrap_seen = 0, ovd_seen = 0, ready_fell = 0;
  int last_addr = -1;

  always @(negedge clk) begin
    if (!rst) begin
      edges_since++;
      if (edges_since <= INIT && (req || !ras_n)) quiet_bad++;
      chk(ras_n == m_ras, "R6 ras_n", ras_n, m_ras);
      chk(casl_n == m_cas && cash_n == m_cas, "R6 cas", casl_n, m_cas);
      chk(addr == m_addr[RB-1:0], "R7 row_addr", addr, m_addr);
      chk(req == ((m_phase == 1) && (m_wake > 0 || m_pend > 0)), "R4 ref_req", req,
          (m_phase == 1) && (m_wake > 0 || m_pend > 0));
      chk(done == m_done, "R5 ref_done", done, m_done);
      chk(ready == m_ready, "R3 mem_ready", ready, m_ready);
      chk(ovd == (m_pend == PMAX), "R9 overdue", ovd, m_pend == PMAX);
      if (!prev_ready && done) wake_dones++;
      if (!prev_ready && ready) begin
        wake_runs.push_back(wake_dones);
        wake_dones = 0;
      end
      if (prev_ready && !ready) begin
        ready_fell = 1;
        wake_dones = 0;
      end
      if (ovd) ovd_seen = 1;
      if (!ras_n) begin
        if (prev_ras) begin
          cas_at_fall = casl_n;
          if (casl_n) begin
            if (last_addr == (1 << RB) - 1 && addr == 0) wrap_seen = 1;
            last_addr = addr;
          end
        end else if (in_mode_phase && casl_n != cas_at_fall) cbr_viol++;
      end
      prev_ras = ras_n;
      prev_ready = ready;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      chk(0, "watchdog expired", cyc, 20000);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ras_n && casl_n && cash_n, "R1 strobes idle in reset", {ras_n, casl_n, cash_n}, 7);
    chk(addr == 0 && !req && !done && !ready && !ovd, "R1 outputs clear in reset",
        {addr, req, done, ready, ovd}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ras_n && !req && !ready, "R1 first cycle after reset", {ras_n, req, ready}, 4);
    // CBR wake-up and steady refresh, grant always given
    mode = 1'b0; gnt = 1'b1;
    repeat (200) @(negedge clk);
    chk(quiet_bad == 0, "R2 quiet during pause", quiet_bad, 0);
    chk(wake_runs.size() >= 1 && wake_runs[0] == WAKE, "R3 wake-up count",
        (wake_runs.size() > 0) ? wake_runs[0] : -1, WAKE);
    // RAS-only refresh, row counter must wrap
    mode = 1'b1;
    repeat (400) @(negedge clk);
    chk(wrap_seen, "R7 row counter wrap", wrap_seen, 1);
    // R8: toggle mode every cycle
    in_mode_phase = 1;
    for (int i = 0; i < 300; i++) begin
      mode = i[0];
      @(negedge clk);
    end
    in_mode_phase = 0;
    chk(cbr_viol == 0, "R8 strobes fixed during refresh", cbr_viol, 0);
    // R9, R10: withhold grant until the retention window is missed
    mode = 1'b0; gnt = 1'b0;
    repeat ((PMAX + 2) * REFI) @(negedge clk);
    chk(ovd_seen, "R9 overdue raised", ovd_seen, 1);
    chk(ready_fell, "R10 ready withdrawn", ready_fell, 1);
    gnt = 1'b1;
    repeat (150) @(negedge clk);
    chk(wake_runs.size() >= 2 && wake_runs[1] == WAKE, "R10 wake-up rerun",
        (wake_runs.size() > 1) ? wake_runs[1] : -1, WAKE);
    // R5: sparse grants
    for (int i = 0; i < 300; i++) begin
      gnt = (i % 5 == 0);
      mode = (i % 97 > 48);
      @(negedge clk);
    end
    summary();
  end
endmodule